// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the control side of an in-order pipeline whose five stages run in order: instruction fetch, decode, operand fetch, execute and operand write-back. Each cycle it looks at the register fields, branch flags and memory requests of the instructions that currently sit in those stages. From them it decides whether fetch must wait, whether decode takes a bubble, which operand path the operand-fetch stage should use, and whether younger instructions must be killed after a branch. It drives control signals only. The datapath, register file, ALU and memory are outside the block.

Fetch and operand fetch share one memory port, so the block arbitrates that port. Branches resolve in the execute stage. Two branch policies are available and can be changed while the pipeline runs. In freeze mode, fetch is held while a branch is in flight. In predict-untaken mode, fetch runs on sequentially, and if the branch is taken the wrong-path instructions are flushed. A policy change takes effect only at a point where no branch is in decode, operand fetch or execute.

Top module: `pipeHazardCtl`

## Requirements
- R1: While reset is asserted, the active policy is freeze (policyNow = 0), whatever policySel is. With all request, branch and write-enable inputs low, every output is 0.
- R2: If fiMemReq and foMemReq are both high and no flush is active, the port goes to operand fetch (memToOperand = 1), and stallFi and bubbleDi are both 1. If only fiMemReq is high, memToOperand is 0 and there is no stall.
- R3: If exWrEn is high and exDst is nonzero and equal to a source field, that operand's select is 1, meaning the execute result.
- R4: If a source field matches a nonzero woDst with woWrEn high, and the execute stage does not match it, the select is 2, meaning the write-back value. When both stages match, the execute stage wins. In every other case the select is 0, meaning the register file.
- R5: A source field equal to register 0 always gives select 0, whatever the destinations are.
- R6: In freeze mode (policyNow = 0), a branch flag in decode, operand fetch or execute sets stallFi and bubbleDi to 1, and all flush outputs stay 0.
- R7: In predict-untaken mode (policyNow = 1), a taken branch in execute (exIsBr and exTaken) sets flushFi, flushDi and flushFo to 1 in that same cycle, and stallFi and bubbleDi to 0.
- R8: In predict-untaken mode, a branch in flight that is not taken causes no stall and no flush.
- R9: A flush overrides a port conflict. While flushFo is high, memToOperand, stallFi and bubbleDi are 0 even if both memory requests are high.
- R10: At each clock edge, policyNow takes the value of policySel only if deIsBr, foIsBr and exIsBr were all low. Otherwise it keeps its value.
- R11: redirect equals exIsBr AND exTaken in either policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| policySel | input | 1 | Requested branch policy: 0 freeze, 1 predict-untaken |
| fiMemReq | input | 1 | Fetch stage wants the shared memory port |
| foMemReq | input | 1 | Operand-fetch stage wants the shared memory port |
| deIsBr | input | 1 | Decode stage holds a branch |
| foIsBr | input | 1 | Operand-fetch stage holds a branch |
| exIsBr | input | 1 | Execute stage holds a branch |
| exTaken | input | 1 | Branch in execute resolved taken |
| foSrcA | input | 5 | First source register of the operand-fetch instruction |
| foSrcB | input | 5 | Second source register of the operand-fetch instruction |
| exDst | input | 5 | Destination register of the execute instruction |
| exWrEn | input | 1 | Execute instruction writes exDst |
| woDst | input | 5 | Destination register of the write-back instruction |
| woWrEn | input | 1 | Write-back instruction writes woDst |
| stallFi | output | 1 | Hold fetch; the fetch is repeated next cycle |
| bubbleDi | output | 1 | Load a bubble into decode |
| flushFi | output | 1 | Kill the instruction in fetch |
| flushDi | output | 1 | Kill the instruction in decode |
| flushFo | output | 1 | Kill the instruction in operand fetch |
| redirect | output | 1 | Load the branch target into the fetch address |
| memToOperand | output | 1 | Shared port granted to operand fetch (0 means fetch) |
| fwdSelA | output | 2 | Operand A path: 0 register file, 1 execute result, 2 write-back value |
| fwdSelB | output | 2 | Operand B path, same encoding as fwdSelA |
| policyNow | output | 1 | Active branch policy: 0 freeze, 1 predict-untaken |

## Verification
The hardest situations to reach are a policy request that arrives while a branch is still in flight, and a taken branch in predict-untaken mode that meets a port conflict in the same cycle. Directed sequences build both on purpose. The bench first holds a branch flag in decode while changing policySel, and checks that policyNow holds and then updates once the flags clear. It then raises both memory requests while a taken branch sits in execute. After that, a long run of random stage contents draws registers from a small set, so that execute and write-back matches, register 0 and branch overlaps occur often. Each cycle is compared against the behavioural model.

// File: rtl/hazPkg.sv
`timescale 1ns/1ps
package hazPkg;
  typedef enum logic {
    POL_FREEZE  = 1'b0,
    POL_UNTAKEN = 1'b1
  } br_policy_e;

  localparam logic [1:0] FWD_REG = 2'd0;
  localparam logic [1:0] FWD_EX  = 2'd1;
  localparam logic [1:0] FWD_WO  = 2'd2;

  // strobes handed from the compare datapath to the control
  typedef struct packed {
    logic brInFlight;
    logic takenEx;
  } haz_strobe_t;
endpackage

// File: rtl/hazDetect.sv
`timescale 1ns/1ps
module hazDetect #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] srcVec,
  input  logic [REG_W-1:0]              exDst,
  input  logic                          exWrEn,
  input  logic [REG_W-1:0]              woDst,
  input  logic                          woWrEn,
  input  logic                          deIsBr,
  input  logic                          foIsBr,
  input  logic                          exIsBr,
  input  logic                          exTaken,
  output logic [NUM_SRC-1:0][1:0]       fwdSel,
  output hazPkg::haz_strobe_t           strb
);
  import hazPkg::*;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic exLive, woLive;
  assign exLive = exWrEn && (exDst != ZERO_REG);
  assign woLive = woWrEn && (woDst != ZERO_REG);

  // one comparator pair per source operand; newest producer wins
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic hitEx, hitWo;
    assign hitEx = exLive && (srcVec[s] == exDst);
    assign hitWo = woLive && (srcVec[s] == woDst);
    always_comb begin
      if (hitEx)      fwdSel[s] = FWD_EX;
      else if (hitWo) fwdSel[s] = FWD_WO;
      else            fwdSel[s] = FWD_REG;
    end
  end

  always_comb begin
    strb.brInFlight = deIsBr | foIsBr | exIsBr;
    strb.takenEx    = exIsBr & exTaken;
  end
endmodule

// File: rtl/hazControl.sv
`timescale 1ns/1ps
module hazControl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                policySel,
  input  logic                fiMemReq,
  input  logic                foMemReq,
  input  hazPkg::haz_strobe_t strb,
  output logic                stallFi,
  output logic                bubbleDi,
  output logic                flushFi,
  output logic                flushDi,
  output logic                flushFo,
  output logic                redirect,
  output logic                memToOperand,
  output hazPkg::br_policy_e  policyNow
);
  import hazPkg::*;

  logic flushAll, freezeNow, portClash;

  // policy only changes when no branch sits between decode and execute
  always_ff @(posedge clk) begin
    if (!rstN)                policyNow <= POL_FREEZE;
    else if (!strb.brInFlight) policyNow <= br_policy_e'(policySel);
  end

  always_comb begin
    flushAll     = (policyNow == POL_UNTAKEN) && strb.takenEx;
    freezeNow    = (policyNow == POL_FREEZE) && strb.brInFlight;
    portClash    = fiMemReq && foMemReq;
    // flush wins: a wrong-path operand fetch gives the port back
    memToOperand = foMemReq && !flushAll;
    stallFi      = !flushAll && (freezeNow || portClash);
    bubbleDi     = stallFi;
    flushFi      = flushAll;
    flushDi      = flushAll;
    flushFo      = flushAll;
    redirect     = strb.takenEx;
  end

  assert_policy_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.brInFlight |=> $stable(policyNow));
  assert_untaken_flush_R7: assert property (@(posedge clk) disable iff (!rstN)
    (policyNow == POL_UNTAKEN && strb.takenEx) |-> (flushFi && flushDi && flushFo && !stallFi));
  assert_freeze_noflush_R6: assert property (@(posedge clk) disable iff (!rstN)
    (policyNow == POL_FREEZE) |-> !(flushFi || flushDi || flushFo));
  assert_flush_port_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushFo |-> (!memToOperand && !stallFi && !bubbleDi));
  assert_port_clash_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fiMemReq && foMemReq && !flushFo) |-> (memToOperand && stallFi));
endmodule

// File: rtl/pipeHazardCtl.sv
`timescale 1ns/1ps
module pipeHazardCtl #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             policySel,
  input  logic             fiMemReq,
  input  logic             foMemReq,
  input  logic             deIsBr,
  input  logic             foIsBr,
  input  logic             exIsBr,
  input  logic             exTaken,
  input  logic [REG_W-1:0] foSrcA,
  input  logic [REG_W-1:0] foSrcB,
  input  logic [REG_W-1:0] exDst,
  input  logic             exWrEn,
  input  logic [REG_W-1:0] woDst,
  input  logic             woWrEn,
  output logic             stallFi,
  output logic             bubbleDi,
  output logic             flushFi,
  output logic             flushDi,
  output logic             flushFo,
  output logic             redirect,
  output logic             memToOperand,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic             policyNow
);
  import hazPkg::*;
  localparam int NUM_SRC = 2;

  haz_strobe_t                 strb;
  logic [NUM_SRC-1:0][REG_W-1:0] srcVec;
  logic [NUM_SRC-1:0][1:0]       selVec;
  br_policy_e                  polQ;

  assign srcVec  = {foSrcB, foSrcA};
  assign fwdSelA = selVec[0];
  assign fwdSelB = selVec[1];
  assign policyNow = polQ;

  hazDetect #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_detect (
    .srcVec (srcVec),
    .exDst  (exDst),
    .exWrEn (exWrEn),
    .woDst  (woDst),
    .woWrEn (woWrEn),
    .deIsBr (deIsBr),
    .foIsBr (foIsBr),
    .exIsBr (exIsBr),
    .exTaken(exTaken),
    .fwdSel (selVec),
    .strb   (strb)
  );

  hazControl u_control (
    .clk         (clk),
    .rstN        (rstN),
    .policySel   (policySel),
    .fiMemReq    (fiMemReq),
    .foMemReq    (foMemReq),
    .strb        (strb),
    .stallFi     (stallFi),
    .bubbleDi    (bubbleDi),
    .flushFi     (flushFi),
    .flushDi     (flushDi),
    .flushFo     (flushFo),
    .redirect    (redirect),
    .memToOperand(memToOperand),
    .policyNow   (polQ)
  );

  assert_r0_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((foSrcA == '0) |-> (fwdSelA == FWD_REG)) and ((foSrcB == '0) |-> (fwdSelB == FWD_REG)));
  assert_ex_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (exWrEn && woWrEn && exDst == woDst && foSrcA == exDst && exDst != '0) |-> (fwdSelA == FWD_EX));
  assert_redirect_R11: assert property (@(posedge clk) disable iff (!rstN)
    redirect == (exIsBr && exTaken));
endmodule

// File: tb/pipeHazardCtl_bench.sv
`timescale 1ns/1ps
module pipeHazardCtl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic policySel = 1'b0, fiMemReq = 1'b0, foMemReq = 1'b0;
  logic deIsBr = 1'b0, foIsBr = 1'b0, exIsBr = 1'b0, exTaken = 1'b0;
  logic [REG_W-1:0] foSrcA = '0, foSrcB = '0, exDst = '0, woDst = '0;
  logic exWrEn = 1'b0, woWrEn = 1'b0;
  logic stallFi, bubbleDi, flushFi, flushDi, flushFo, redirect, memToOperand, policyNow;
  logic [1:0] fwdSelA, fwdSelB;

  int errCount = 0;
  int chkCount = 0;
  int modelPol = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipeHazardCtl #(.REG_W(REG_W)) u_pipeHazardCtl (
    .clk(clk), .rstN(rstN), .policySel(policySel), .fiMemReq(fiMemReq), .foMemReq(foMemReq),
    .deIsBr(deIsBr), .foIsBr(foIsBr), .exIsBr(exIsBr), .exTaken(exTaken),
    .foSrcA(foSrcA), .foSrcB(foSrcB), .exDst(exDst), .exWrEn(exWrEn),
    .woDst(woDst), .woWrEn(woWrEn), .stallFi(stallFi), .bubbleDi(bubbleDi),
    .flushFi(flushFi), .flushDi(flushDi), .flushFo(flushFo), .redirect(redirect),
    .memToOperand(memToOperand), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .policyNow(policyNow)
  );

  task automatic chk(string tag, int act, int exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expSel(int src);
    if (src == 0) return 0;                                  // R5
    if (exWrEn && exDst != 0 && int'(exDst) == src) return 1; // R3
    if (woWrEn && woDst != 0 && int'(woDst) == src) return 2; // R4
    return 0;
  endfunction

  // behavioural reference compared at mid-cycle
  task automatic compareAll();
    int taken, inFlight, flushAll, freeze, expStall;
    taken    = (exIsBr && exTaken) ? 1 : 0;
    inFlight = (deIsBr || foIsBr || exIsBr) ? 1 : 0;
    flushAll = (modelPol == 1 && taken == 1) ? 1 : 0;
    freeze   = (modelPol == 0 && inFlight == 1) ? 1 : 0;
    expStall = (flushAll == 0 && (freeze == 1 || (fiMemReq && foMemReq))) ? 1 : 0;
    chk("R10 policyNow", int'(policyNow), modelPol);
    chk("R3/R4/R5 fwdSelA", int'(fwdSelA), expSel(int'(foSrcA)));
    chk("R3/R4/R5 fwdSelB", int'(fwdSelB), expSel(int'(foSrcB)));
    chk("R2/R6/R9 stallFi", int'(stallFi), expStall);
    chk("R2/R6 bubbleDi", int'(bubbleDi), expStall);
    chk("R7 flushFi", int'(flushFi), flushAll);
    chk("R7 flushDi", int'(flushDi), flushAll);
    chk("R7/R9 flushFo", int'(flushFo), flushAll);
    chk("R11 redirect", int'(redirect), taken);
    chk("R2/R9 memToOperand", int'(memToOperand), (foMemReq && flushAll == 0) ? 1 : 0);
  endtask

  // one cycle: inputs already set after a negedge; check, advance model, wait
  task automatic step();
    #1;
    compareAll();
    if (!rstN) modelPol = 0;
    else if (!(deIsBr || foIsBr || exIsBr)) modelPol = int'(policySel);
    @(negedge clk);
  endtask

  task automatic setBr(logic d, logic f, logic e, logic t);
    deIsBr = d; foIsBr = f; exIsBr = e; exTaken = t;
  endtask

  task automatic quiet();
    fiMemReq = 0; foMemReq = 0; setBr(0, 0, 0, 0);
    exWrEn = 0; woWrEn = 0; foSrcA = '0; foSrcB = '0; exDst = '0; woDst = '0;
  endtask

  initial begin
    @(negedge clk);
    // R1: reset forces freeze even with predict-untaken requested
    policySel = 1;
    step(); step();
    chk("R1 reset policy", int'(policyNow), 0);
    rstN = 1; policySel = 0;
    step();
    chk("R1 idle stall", int'(stallFi), 0);
    chk("R1 idle grant", int'(memToOperand), 0);

    // R3 R4 R5 forwarding patterns
    exWrEn = 1; exDst = 5'd3; foSrcA = 5'd3; foSrcB = 5'd4; step();
    woWrEn = 1; woDst = 5'd4; step();
    woDst = 5'd3; foSrcB = 5'd3; step();              // both match: R4 execute wins
    exDst = 5'd0; woDst = 5'd0; foSrcA = 5'd0; foSrcB = 5'd0; step(); // R5
    exWrEn = 0; exDst = 5'd7; foSrcA = 5'd7; step();  // write enable low
    quiet();

    // R2 port arbitration in freeze mode without branches
    fiMemReq = 1; step();
    foMemReq = 1; step();
    chk("R2 clash stall", int'(stallFi), 1);
    fiMemReq = 0; step();
    quiet();

    // R6 R11 freeze walk of a taken branch
    setBr(1, 0, 0, 0); step();
    setBr(0, 1, 0, 0); step();
    setBr(0, 0, 1, 1); step();
    chk("R11 freeze redirect", int'(redirect), 1);
    chk("R6 freeze no flush", int'(flushFo), 0);
    quiet();

    // R10 policy request while branch in flight is deferred
    policySel = 1; setBr(1, 0, 0, 0); step();
    chk("R10 held", int'(policyNow), 0);
    setBr(0, 0, 1, 0); step();
    chk("R10 still held", int'(policyNow), 0);
    setBr(0, 0, 0, 0); step();
    chk("R10 updated", int'(policyNow), 1);

    // R8 untaken, R7 taken, R9 taken plus port clash
    setBr(1, 1, 1, 0); fiMemReq = 1; step();
    chk("R8 no stall", int'(stallFi), 0);
    setBr(0, 0, 1, 1); step();
    chk("R7 flush", int'(flushDi), 1);
    foMemReq = 1; setBr(0, 1, 1, 1); step();
    chk("R9 flush beats clash", int'(memToOperand), 0);
    quiet();

    // random stage contents drawn from a small register set
    for (int i = 0; i < 3000; i++) begin
      fiMemReq = ($urandom_range(3) != 0);
      foMemReq = ($urandom_range(2) == 0);
      deIsBr = ($urandom_range(5) == 0);
      foIsBr = ($urandom_range(5) == 0);
      exIsBr = ($urandom_range(4) == 0);
      exTaken = exIsBr && ($urandom_range(1) == 1);
      foSrcA = REG_W'($urandom_range(3));
      foSrcB = REG_W'($urandom_range(3));
      exDst = REG_W'($urandom_range(3));
      woDst = REG_W'($urandom_range(3));
      exWrEn = ($urandom_range(3) != 0);
      woWrEn = ($urandom_range(3) != 0);
      if ($urandom_range(15) == 0) policySel = ~policySel;
      step();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errCount++;
      chkCount++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end
endmodule